// File: doc/BRIEF.md
# Interrupt Level Encoder and Acknowledge Responder

This block sits between up to seven interrupting peripherals and a processor that takes a 3-bit active-low priority code on its interrupt inputs. Requests arrive as active-high lines, one per level. Each line is latched into a pending bit. The highest pending level is driven to the processor on `ipl_n`. The code is frozen once the processor starts an interrupt acknowledge cycle, so the level it samples cannot shift under it.

The processor signals an acknowledge cycle with the function code `111` and address strobe low. In that cycle the address bus carries the serviced level on bits 3..1, and all other bits are high. If that level equals the level the block is presenting, the block answers in one of two ways, chosen per level. It can drive an 8-bit vector on the low data byte and pull the data acknowledge low. Or it can pull the autovector line low. When the strobe rises, the pending bit of the serviced level is cleared, and the next level is presented.

Vectors and response modes are loaded through a valid/ready write port. A write is taken on a clock edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` drops while an acknowledge cycle is running and during the clear that follows it. While `cfg_valid` is high and `cfg_ready` is low, the sender must hold the level, vector and mode fields stable. No write is lost or applied twice.

Top module: `irq_level_responder`

## Requirements
- R1: After reset, `ipl_n` is `111`, `dtack_n` and `avec_n` are high, `data_oe` is low and `cfg_ready` is high. Every level resets to autovector mode, with vector `0x40 + level`.
- R2: `ipl_n` carries the bitwise inverse of the highest pending level. Bit 0 is the least significant bit of the level. Level 7 wins over all others and no level is masked. The level appears two clock edges after its request is sampled.
- R3: While `as_n` is low with `fc` = `111`, and until the serviced level has been cleared, `ipl_n` does not change, even if new requests arrive.
- R4: An acknowledge cycle is recognised only when all of these hold: `as_n` is low, `fc` = `111`, `addr[23:4]` are all ones and `addr[0]` is one. Any other cycle gets no response.
- R5: A matching acknowledge for a level in vectored mode (mode bit 0) pulls `dtack_n` low and sets `data_oe`, with the level's vector on `data_out`. This happens from the first clock edge that samples the cycle until `as_n` rises, and the outputs release in the same cycle that `as_n` rises.
- R6: A matching acknowledge for a level in autovector mode (mode bit 1) pulls `avec_n` low and leaves `dtack_n` high and `data_oe` low. `avec_n` is never low outside a recognised acknowledge cycle.
- R7: An acknowledge whose `addr[3:1]` differs from the presented level gets neither `dtack_n` nor `avec_n`, and no pending level is cleared.
- R8: When `as_n` rises after an answered acknowledge, the serviced level's pending bit clears. The next highest pending level then appears on `ipl_n`.
- R9: A level listed in `EDGE_SRC` (levels 1 and 2 by default) becomes pending on a rising edge of its request, so a one-cycle pulse is kept until serviced and a held-high request does not pend again. Any other level becomes pending whenever its request is high, so a request still held after service stays pending.
- R10: A write with `cfg_valid` and `cfg_ready` both high stores `cfg_vector` and `cfg_auto` for `cfg_level` (1..7). `cfg_ready` is low during an acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 7 | Active-high requests; bit i is level i+1 |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_ready | output | 1 | Configuration write ready |
| cfg_level | input | 3 | Level being configured (1..7) |
| cfg_vector | input | 8 | Vector number for that level |
| cfg_auto | input | 1 | 1 = autovector response, 0 = vectored |
| as_n | input | 1 | Address strobe, active low |
| fc | input | 3 | Processor function code |
| addr | input | 24 | Processor address bus |
| ipl_n | output | 3 | Active-low encoded priority level |
| dtack_n | output | 1 | Data acknowledge, active low |
| avec_n | output | 1 | Autovector request, active low |
| data_out | output | 8 | Vector number for the low data byte |
| data_oe | output | 1 | Enable for driving `data_out` |

## Verification
The bench raises a new top-priority request in the middle of an acknowledge. A design that recomputed the code mid-cycle would change `ipl_n` there and fail. It sends acknowledges with a wrong level, a wrong function code and a wrong upper address bit. A sloppy decoder would answer those or clear the wrong pending bit. It also holds an edge-type request high across service and holds a level-type request high across service. A design that mixed up the two kinds would either pend again forever or drop the still-active request. Finally, it checks that the response lines release in the same cycle the strobe rises. A registered release would leave `avec_n` low outside the acknowledge.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam logic [2:0] FC_IACK = 3'b111;

  // highest set bit, reported as a level number (0 = nothing pending)
  function automatic lvl_t top_level(input logic [NUM_LVL-1:0] pend);
    lvl_t r;
    r = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (pend[i]) r = lvl_t'(i + 1);
    return r;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_resp_pkg::*;
#(
  parameter logic [NUM_LVL-1:0] EDGE_SRC = 7'b000_0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] req,
  input  logic               clr_en,
  input  lvl_t               clr_lvl,
  output logic [NUM_LVL-1:0] pend
);
  logic [NUM_LVL-1:0] set_v;
  logic [NUM_LVL-1:0] pend_q;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_src
    if (EDGE_SRC[g]) begin : g_edge
      logic req_q;
      always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req[g];
      end
      assign set_v[g] = req[g] & ~req_q;
    end else begin : g_lvl
      assign set_v[g] = req[g];
    end

    logic clr_hit;
    assign clr_hit = clr_en && (clr_lvl == lvl_t'(g + 1));

    // a new request in the clearing cycle wins over the clear
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= set_v[g] | (pend_q[g] & ~clr_hit);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank
  import irq_resp_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  lvl_t             wr_lvl,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             wr_auto,
  input  lvl_t             rd_lvl,
  output logic [VEC_W-1:0] rd_vec,
  output logic             rd_auto
);
  logic [VEC_W-1:0]   vec_q [NUM_LVL];
  logic [NUM_LVL-1:0] auto_q;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_q[g]  <= VEC_W'(VEC_BASE + g + 1);
        auto_q[g] <= 1'b1;
      end else if (wr_en && (wr_lvl == lvl_t'(g + 1))) begin
        vec_q[g]  <= wr_vec;
        auto_q[g] <= wr_auto;
      end
    end
  end

  always_comb begin
    rd_vec  = '0;
    rd_auto = 1'b0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (rd_lvl == lvl_t'(i + 1)) begin
        rd_vec  = vec_q[i];
        rd_auto = auto_q[i];
      end
    end
  end
endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp
  import irq_resp_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic [2:0]        fc,
  input  logic [ADDR_W-1:0] addr,
  input  lvl_t              cur_lvl,
  input  logic [VEC_W-1:0]  rd_vec,
  input  logic              rd_auto,
  output lvl_t              rd_lvl,
  output logic              dtack_n,
  output logic              avec_n,
  output logic [VEC_W-1:0]  data_out,
  output logic              data_oe,
  output logic              freeze,
  output logic              clr_en,
  output lvl_t              clr_lvl
);
  logic             fc_ack, ack_now, hit_now;
  logic             served_q, auto_q;
  lvl_t             lvl_q;
  logic [VEC_W-1:0] vec_q;

  assign fc_ack  = !as_n && (fc == FC_IACK);
  assign ack_now = fc_ack && (&addr[ADDR_W-1:LVL_W+1]) && addr[0];
  assign rd_lvl  = addr[LVL_W:1];
  assign hit_now = ack_now && (rd_lvl == cur_lvl) && (cur_lvl != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      served_q <= 1'b0;
      auto_q   <= 1'b0;
      lvl_q    <= '0;
      vec_q    <= '0;
    end else if (as_n) begin
      served_q <= 1'b0;
    end else if (hit_now && !served_q) begin
      served_q <= 1'b1;
      auto_q   <= rd_auto;
      lvl_q    <= rd_lvl;
      vec_q    <= rd_vec;
    end
  end

  logic drive;
  assign drive    = served_q && hit_now;
  assign dtack_n  = !(drive && !auto_q);
  assign avec_n   = !(drive && auto_q);
  assign data_oe  = drive && !auto_q;
  assign data_out = data_oe ? vec_q : '0;
  assign freeze   = fc_ack || served_q;
  assign clr_en   = served_q && as_n;
  assign clr_lvl  = lvl_q;
endmodule

// File: rtl/irq_level_responder.sv
module irq_level_responder
  import irq_resp_pkg::*;
#(
  parameter int                 VEC_W    = 8,
  parameter int                 ADDR_W   = 24,
  parameter int                 VEC_BASE = 64,
  parameter logic [NUM_LVL-1:0] EDGE_SRC = 7'b000_0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_req,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic [VEC_W-1:0]   cfg_vector,
  input  logic               cfg_auto,
  input  logic               as_n,
  input  logic [2:0]         fc,
  input  logic [ADDR_W-1:0]  addr,
  output logic [LVL_W-1:0]   ipl_n,
  output logic               dtack_n,
  output logic               avec_n,
  output logic [VEC_W-1:0]   data_out,
  output logic               data_oe
);
  logic [NUM_LVL-1:0] pend;
  logic               freeze, clr_en, rd_auto;
  lvl_t               clr_lvl, rd_lvl, ipl_q;
  logic [VEC_W-1:0]   rd_vec;

  irq_pend_bank #(.EDGE_SRC(EDGE_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(irq_req),
    .clr_en(clr_en), .clr_lvl(clr_lvl), .pend(pend)
  );

  irq_vec_bank #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vec (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_valid && cfg_ready),
    .wr_lvl(cfg_level), .wr_vec(cfg_vector), .wr_auto(cfg_auto),
    .rd_lvl(rd_lvl), .rd_vec(rd_vec), .rd_auto(rd_auto)
  );

  irq_ack_resp #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .fc(fc), .addr(addr),
    .cur_lvl(ipl_q), .rd_vec(rd_vec), .rd_auto(rd_auto), .rd_lvl(rd_lvl),
    .dtack_n(dtack_n), .avec_n(avec_n), .data_out(data_out),
    .data_oe(data_oe), .freeze(freeze), .clr_en(clr_en), .clr_lvl(clr_lvl)
  );

  // presented level only moves outside an acknowledge and its clear
  always_ff @(posedge clk) begin
    if (!rst_n)       ipl_q <= '0;
    else if (!freeze) ipl_q <= top_level(pend);
  end

  assign ipl_n     = ~ipl_q;
  assign cfg_ready = !freeze;
endmodule

// File: rtl/irq_resp_chk.sv
module irq_resp_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              as_n,
  input logic [2:0]        fc,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        ipl_n,
  input logic              dtack_n,
  input logic              avec_n,
  input logic              data_oe,
  input logic              cfg_ready
);
  logic fc_ack, full_ack;
  assign fc_ack   = !as_n && (fc == 3'b111);
  assign full_ack = fc_ack && (&addr[ADDR_W-1:4]) && addr[0];

  // R3
  ipl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_ack && $past(fc_ack)) |-> $stable(ipl_n));
  // R6
  avec_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avec_n |-> full_ack);
  // R5
  one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !avec_n));
  // R5
  oe_with_dtack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !dtack_n);
  // R7
  mismatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_ack && (addr[3:1] != ~ipl_n)) |-> (dtack_n && avec_n));
  // R10
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fc_ack |-> !cfg_ready);
endmodule

bind irq_level_responder irq_resp_chk #(.ADDR_W(ADDR_W)) u_resp_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .fc(fc), .addr(addr),
  .ipl_n(ipl_n), .dtack_n(dtack_n), .avec_n(avec_n),
  .data_oe(data_oe), .cfg_ready(cfg_ready)
);

// File: tb/test_irq_level_responder.sv
module test_irq_level_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_req = '0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [2:0]  cfg_level = '0;
  logic [7:0]  cfg_vector = '0;
  logic        cfg_auto = 1'b0;
  logic        as_n = 1'b1;
  logic [2:0]  fc = '0;
  logic [23:0] addr = '0;
  logic [2:0]  ipl_n;
  logic        dtack_n, avec_n, data_oe;
  logic [7:0]  data_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_level_responder i_irq_level_responder (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_level(cfg_level), .cfg_vector(cfg_vector),
    .cfg_auto(cfg_auto), .as_n(as_n), .fc(fc), .addr(addr), .ipl_n(ipl_n),
    .dtack_n(dtack_n), .avec_n(avec_n), .data_out(data_out), .data_oe(data_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ack_begin(input logic [2:0] lvl, input logic [2:0] f, input logic top_ok);
    as_n = 1'b0;
    fc   = f;
    addr = {top_ok, 19'h7FFFF, lvl, 1'b1};
    tick(1);
  endtask

  task automatic ack_end();
    as_n = 1'b1;
    #1;
    chk("R5 dtack_n released with strobe", dtack_n, 1);
    chk("R6 avec_n released with strobe", avec_n, 1);
    fc = '0; addr = '0;
    tick(3);
  endtask

  task automatic pulse(input logic [6:0] r);
    irq_req = r; tick(1); irq_req = '0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1 ipl_n", ipl_n, 7);
    chk("R1 dtack_n", dtack_n, 1);
    chk("R1 avec_n", avec_n, 1);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 cfg_ready", cfg_ready, 1);
  endtask

  task automatic t_config();
    chk("R10 ready idle", cfg_ready, 1);
    cfg_valid = 1'b1; cfg_level = 3'd5; cfg_vector = 8'hA5; cfg_auto = 1'b0;
    tick(1);
    cfg_level = 3'd3; cfg_vector = 8'h33;
    tick(1);
    cfg_valid = 1'b0;
  endtask

  task automatic t_priority();
    pulse(7'b001_0100);  // levels 3 and 5, level-type
    chk("R2 level 5 wins over 3", ipl_n, 3'b010);
  endtask

  task automatic t_vectored_hold();
    ack_begin(3'd5, 3'b111, 1'b1);
    chk("R5 dtack_n low", dtack_n, 0);
    chk("R5 data_oe", data_oe, 1);
    chk("R5 vector", data_out, 8'hA5);
    chk("R5 no avec", avec_n, 1);
    chk("R10 ready low in ack", cfg_ready, 0);
    irq_req = 7'b100_0000;
    tick(2);
    chk("R3 code held in ack", ipl_n, 3'b010);
    chk("R5 dtack_n still low", dtack_n, 0);
    ack_end();
    irq_req = '0;
    chk("R2 level 7 after clear", ipl_n, 3'b000);
  endtask

  task automatic t_autovector();
    ack_begin(3'd7, 3'b111, 1'b1);
    chk("R6 avec_n low", avec_n, 0);
    chk("R6 dtack_n high", dtack_n, 1);
    chk("R6 data_oe low", data_oe, 0);
    ack_end();
    chk("R8 next level 3", ipl_n, 3'b100);
  endtask

  task automatic t_bad_cycles();
    ack_begin(3'd6, 3'b111, 1'b1);
    chk("R7 mismatch dtack_n", dtack_n, 1);
    chk("R7 mismatch avec_n", avec_n, 1);
    ack_end();
    chk("R7 level 3 not cleared", ipl_n, 3'b100);
    ack_begin(3'd3, 3'b101, 1'b1);
    chk("R4 wrong fc dtack_n", dtack_n, 1);
    chk("R4 wrong fc avec_n", avec_n, 1);
    ack_end();
    ack_begin(3'd3, 3'b111, 1'b0);
    chk("R4 addr23 low dtack_n", dtack_n, 1);
    ack_end();
    chk("R4 level 3 still pending", ipl_n, 3'b100);
  endtask

  task automatic t_last_vector();
    ack_begin(3'd3, 3'b111, 1'b1);
    chk("R5 level 3 vector", data_out, 8'h33);
    chk("R5 level 3 dtack_n", dtack_n, 0);
    ack_end();
    chk("R8 nothing pending", ipl_n, 3'b111);
  endtask

  task automatic t_edge_sources();
    pulse(7'b000_0010);  // level 2 one-cycle pulse, edge-type
    chk("R9 short pulse kept", ipl_n, 3'b101);
    ack_begin(3'd2, 3'b111, 1'b1);
    chk("R1 level 2 default autovector", avec_n, 0);
    ack_end();
    chk("R8 level 2 cleared", ipl_n, 3'b111);
    irq_req = 7'b000_0001; tick(3);
    chk("R9 level 1 pending", ipl_n, 3'b110);
    ack_begin(3'd1, 3'b111, 1'b1);
    ack_end();
    chk("R9 held edge source not re-pended", ipl_n, 3'b111);
    irq_req = 7'b000_1000; tick(3);
    chk("R9 level 4 pending", ipl_n, 3'b011);
    ack_begin(3'd4, 3'b111, 1'b1);
    ack_end();
    chk("R9 held level source stays", ipl_n, 3'b011);
    irq_req = '0;
    ack_begin(3'd4, 3'b111, 1'b1);
    ack_end();
    chk("R9 level 4 cleared once dropped", ipl_n, 3'b111);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_config();
    t_priority();
    t_vectored_hold();
    t_autovector();
    t_bad_cycles();
    t_last_vector();
    t_edge_sources();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule